// File: doc/BRIEF.md
# Serial Channel Bring-Up Sequencer

This block provisions one serial transceiver channel after reset with no help from software. When `start` is pulsed, it works through a fixed script on a small register bus. It programs the rate word. It sets the clock-recovery threshold and frequency-multiplier fields. It programs the parallel-interface mode word, which depends on `align_mode`. It then polls until the channel PLL reports lock.

Next it pulses the receiver enable bit low and then high. It waits for the gain control loop to lock, or for a unit-interval budget to run out, whichever comes first. It then moves the frequency multiplier to its tracking setting, confirms gain lock, and pulses the datapath reset bit. Finally it reads the latched status register and the error counter so that both are cleared, and raises `done`. If a poll runs out of attempts, the script stops and `err` is raised.

The bus carries one transaction at a time. A write is a single-cycle strobe with address and data. A read is a single-cycle strobe, and the read data arrives later on a one-cycle valid. Every write that changes only some bits of a register is done as a read-modify-write, so the other bits of that register keep their values.

Top module: `bringup_seq`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `bus_wr` and `bus_rd` are all low. A `start` pulse while idle raises `busy` until the script ends in done or in error.
- R2: The first bus transaction is a write of 0x01FD to address 1.
- R3: Address 8 is read and then written back with bits 11:10 forced to 01 and bits 9:8 forced to 00. All other bits keep the value that was read.
- R4: Address 3 is set according to `align_mode`, which is captured at start. Code 0 reads the register and writes it back with bits 6, 3, 2, 1 and 0 set. Codes 1, 2 and 3 write the full words 0x018C, 0x018F and 0x01CC.
- R5: Address 5 is read repeatedly until bit 0 is 1. If POLL_MAX reads in a row return 0, `err` rises, `busy` falls and no further bus transaction follows.
- R6: Address 20 bit 2 is written 0 by one read-modify-write, then 1 by a second. All other bits of address 20 are kept.
- R7: After the enable pulse, address 5 is polled until bit 13 is 1 or UI_TIMEOUT cycles have passed. Either exit leads to a read-modify-write of address 8 that forces bits 9:8 to 01 and keeps the other bits.
- R8: Address 5 is then polled until bit 13 is 1, with the same POLL_MAX limit and error behaviour as R5. After that, address 4 is rewritten with bit 3 set and its other bits kept.
- R9: The last two reads are address 5 and then address 14. Only after those reads does `done` rise, `busy` fall, and `done` stay high until the next start. `done` and `err` are never high together.
- R10: Each bus strobe lasts one cycle. `bus_rd` and `bus_wr` are never high together. No new strobe is issued while a read is waiting for its valid.
- R11: `start` has no effect while `busy` is high. A new `start` while idle clears `done` and `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin the script when idle |
| align_mode | input | 2 | Parallel-interface mode code, captured at start |
| bus_addr | output | 5 | Register address |
| bus_wdata | output | 16 | Write data |
| bus_wr | output | 1 | One-cycle write strobe |
| bus_rd | output | 1 | One-cycle read strobe |
| bus_rdata | input | 16 | Read data, valid while `bus_rvalid` is high |
| bus_rvalid | input | 1 | One-cycle read-data valid |
| busy | output | 1 | Script in progress |
| done | output | 1 | Script completed |
| err | output | 1 | A poll ran out of attempts |

## Verification
The assertions assume that the register responder raises `bus_rvalid` only while a read is outstanding, and exactly once for each read strobe. They also assume that `bus_rdata` is meaningful only in that valid cycle. The bench responder keeps to this: it answers every read exactly one cycle after it sees the strobe, and never answers otherwise. It produces the lock bits from flags that the test sequence sets, including the case where a lock bit never appears.

// File: rtl/bringup_pkg.sv
package bringup_pkg;

  localparam int ADDR_W = 5;
  localparam int DATA_W = 16;
  localparam int NSTEP  = 12;
  localparam int IDX_W  = $clog2(NSTEP + 1);

  localparam logic [ADDR_W-1:0] REG_RATE   = 5'd1;
  localparam logic [ADDR_W-1:0] REG_MODE   = 5'd3;
  localparam logic [ADDR_W-1:0] REG_RESET  = 5'd4;
  localparam logic [ADDR_W-1:0] REG_STAT   = 5'd5;
  localparam logic [ADDR_W-1:0] REG_CDR    = 5'd8;
  localparam logic [ADDR_W-1:0] REG_ERRCNT = 5'd14;
  localparam logic [ADDR_W-1:0] REG_RXEN   = 5'd20;

  typedef enum logic [2:0] {OP_WR, OP_RMW, OP_POLL, OP_WAIT, OP_RD, OP_END} op_e;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_RWAIT, ST_NEXT} seq_state_e;

  // clr: bits forced low, set: bits forced high (or poll mask / write word)
  typedef struct packed {
    op_e               op;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] clr;
    logic [DATA_W-1:0] set;
  } step_t;

  function automatic logic [DATA_W-1:0] rmw_merge(input logic [DATA_W-1:0] old,
                                                  input logic [DATA_W-1:0] clr,
                                                  input logic [DATA_W-1:0] set);
    return (old & ~clr) | set;
  endfunction

  function automatic logic [DATA_W-1:0] align_word(input logic [1:0] mode);
    case (mode)
      2'd1:    return 16'h018C;
      2'd2:    return 16'h018F;
      default: return 16'h01CC;
    endcase
  endfunction

  function automatic step_t mk(input op_e op, input logic [ADDR_W-1:0] a,
                               input logic [DATA_W-1:0] c, input logic [DATA_W-1:0] s);
    step_t t;
    t.op = op; t.addr = a; t.clr = c; t.set = s;
    return t;
  endfunction

  function automatic step_t step_at(input logic [IDX_W-1:0] idx, input logic [1:0] mode);
    case (idx)
      4'd0:    return mk(OP_WR,   REG_RATE,   16'h0000, 16'h01FD);
      4'd1:    return mk(OP_RMW,  REG_CDR,    16'h0F00, 16'h0400);
      4'd2:    return (mode == 2'd0) ? mk(OP_RMW, REG_MODE, 16'h0000, 16'h004F)
                                     : mk(OP_WR,  REG_MODE, 16'h0000, align_word(mode));
      4'd3:    return mk(OP_POLL, REG_STAT,   16'h0000, 16'h0001);
      4'd4:    return mk(OP_RMW,  REG_RXEN,   16'h0004, 16'h0000);
      4'd5:    return mk(OP_RMW,  REG_RXEN,   16'h0000, 16'h0004);
      4'd6:    return mk(OP_WAIT, REG_STAT,   16'h0000, 16'h2000);
      4'd7:    return mk(OP_RMW,  REG_CDR,    16'h0300, 16'h0100);
      4'd8:    return mk(OP_POLL, REG_STAT,   16'h0000, 16'h2000);
      4'd9:    return mk(OP_RMW,  REG_RESET,  16'h0000, 16'h0008);
      4'd10:   return mk(OP_RD,   REG_STAT,   16'h0000, 16'h0000);
      4'd11:   return mk(OP_RD,   REG_ERRCNT, 16'h0000, 16'h0000);
      default: return mk(OP_END,  '0,         16'h0000, 16'h0000);
    endcase
  endfunction

endpackage

// File: rtl/bringup_cnt.sv
module bringup_cnt #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic at_limit,
  output logic near
);
  localparam int W = $clog2(LIMIT + 1);
  logic [W-1:0] cnt;

  assign at_limit = (cnt == W'(LIMIT));
  assign near     = (cnt == W'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt <= '0;
    else if (inc && !at_limit) cnt <= cnt + 1'b1;
  end

  // counter saturates instead of wrapping (poll limit / timeout, R5 R7)
  assert_cnt_saturate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (at_limit && !clr) |=> at_limit);
endmodule

// File: rtl/bringup_busport.sv
module bringup_busport import bringup_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_rd,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              bus_rvalid,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic              outstanding
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_addr <= '0; bus_wdata <= '0; bus_rd <= 1'b0; bus_wr <= 1'b0; outstanding <= 1'b0;
    end else begin
      bus_rd <= req_rd;
      bus_wr <= req_wr;
      if (req_rd || req_wr) bus_addr <= req_addr;
      if (req_wr) bus_wdata <= req_wdata;
      if (req_rd) outstanding <= 1'b1;
      else if (bus_rvalid) outstanding <= 1'b0;
    end
  end

  assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));
  assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (outstanding && !bus_rvalid) |-> !(req_rd || req_wr));
  assert_rvalid_expected_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> outstanding);
  assert_strobe_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> !bus_rd);
endmodule

// File: rtl/bringup_seq.sv
module bringup_seq import bringup_pkg::*; #(
  parameter int POLL_MAX   = 64,
  parameter int UI_TIMEOUT = 25_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        align_mode,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_wr,
  output logic              bus_rd,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_rvalid,
  output logic              busy,
  output logic              done,
  output logic              err
);
  seq_state_e        state, nxt;
  logic [IDX_W-1:0]  idx;
  logic [1:0]        align_q;
  step_t             cur;
  logic              req_rd, req_wr;
  logic [DATA_W-1:0] req_wdata;
  logic              set_done, set_err;
  logic              outstanding;

  // named events for the assertions
  logic poll_hit, rsp, poll_last, ui_expired, ui_unused, poll_unused;
  logic cnt_clr, poll_miss, in_wait;

  assign cur       = step_at(idx, align_q);
  assign poll_hit  = |(bus_rdata & cur.set);
  assign rsp       = (state == ST_RWAIT) && bus_rvalid;
  assign cnt_clr   = (state == ST_NEXT) || (state == ST_IDLE);
  assign poll_miss = rsp && (cur.op == OP_POLL || cur.op == OP_WAIT) && !poll_hit;
  assign in_wait   = (state != ST_IDLE) && (cur.op == OP_WAIT);
  assign busy      = (state != ST_IDLE);

  bringup_cnt #(.LIMIT(POLL_MAX)) u_poll (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(poll_miss),
    .at_limit(poll_unused), .near(poll_last));

  bringup_cnt #(.LIMIT(UI_TIMEOUT)) u_ui (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(in_wait),
    .at_limit(ui_expired), .near(ui_unused));

  bringup_busport u_bus (
    .clk(clk), .rst_n(rst_n), .req_rd(req_rd), .req_wr(req_wr),
    .req_addr(cur.addr), .req_wdata(req_wdata), .bus_rvalid(bus_rvalid),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .outstanding(outstanding));

  always_comb begin
    nxt = state; req_rd = 1'b0; req_wr = 1'b0; req_wdata = cur.set;
    set_done = 1'b0; set_err = 1'b0;
    case (state)
      ST_IDLE: if (start) nxt = ST_ISSUE;
      ST_ISSUE: begin
        case (cur.op)
          OP_WR:   begin req_wr = 1'b1; nxt = ST_NEXT; end
          OP_END:  begin set_done = 1'b1; nxt = ST_IDLE; end
          default: begin req_rd = 1'b1; nxt = ST_RWAIT; end
        endcase
      end
      ST_RWAIT: if (bus_rvalid) begin
        case (cur.op)
          OP_RMW: begin
            req_wr = 1'b1;
            req_wdata = rmw_merge(bus_rdata, cur.clr, cur.set);
            nxt = ST_NEXT;
          end
          OP_POLL: begin
            if (poll_hit)       nxt = ST_NEXT;
            else if (poll_last) begin set_err = 1'b1; nxt = ST_IDLE; end
            else                nxt = ST_ISSUE;
          end
          OP_WAIT: nxt = (poll_hit || ui_expired) ? ST_NEXT : ST_ISSUE;
          default: nxt = ST_NEXT;
        endcase
      end
      ST_NEXT: nxt = ST_ISSUE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE; idx <= '0; align_q <= 2'd0; done <= 1'b0; err <= 1'b0;
    end else begin
      state <= nxt;
      if (state == ST_IDLE && start) begin
        idx <= '0; align_q <= align_mode; done <= 1'b0; err <= 1'b0;
      end
      if (state == ST_NEXT) idx <= idx + 1'b1;
      if (set_done) done <= 1'b1;
      if (set_err)  err  <= 1'b1;
    end
  end

  assert_done_err_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));
  assert_done_after_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (bus_addr == REG_ERRCNT));
  assert_err_from_poll_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(cur.op == OP_POLL));
  assert_quiet_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(bus_rd || bus_wr));
  assert_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && state != ST_NEXT) |=> $stable(idx));
endmodule

// File: tb/tb_bringup_seq.sv
module tb_bringup_seq;
  localparam int POLL_MAX = 8;
  localparam int UI_TMO   = 300;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  align_mode = 2'd0;
  logic [4:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic        bus_wr, bus_rd, busy, done, err;
  logic [15:0] bus_rdata = '0;
  logic        bus_rvalid = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  bringup_seq #(.POLL_MAX(POLL_MAX), .UI_TIMEOUT(UI_TMO)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .align_mode(align_mode),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .busy(busy), .done(done), .err(err));

  int vectors = 0, misses = 0;
  logic [15:0] regs [0:31];
  logic        pll_ok = 1'b0, agc_ok = 1'b0;
  logic        pend = 1'b0;
  logic [4:0]  pend_addr = '0;
  int          cyc = 0, wr_cnt = 0, rd5_cnt = 0, rd5_after6 = 0;
  int          wr_cyc [0:15];
  logic [4:0]  last_rd = '0, prev_rd = '0;
  logic [20:0] expq [$];

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp_v);
    end
  endtask

  task automatic push(input logic [4:0] a, input logic [15:0] d);
    expq.push_back({a, d});
  endtask

  // responder plus scoreboard monitor
  always @(negedge clk) begin
    cyc++;
    bus_rvalid = 1'b0;
    if (pend) begin
      bus_rvalid = 1'b1;
      bus_rdata = (pend_addr == 5'd5) ? {2'b00, agc_ok, 12'h000, pll_ok} : regs[pend_addr];
      pend = 1'b0;
    end
    if (bus_rd) begin
      pend = 1'b1; pend_addr = bus_addr;
      prev_rd = last_rd; last_rd = bus_addr;
      if (bus_addr == 5'd5) begin
        rd5_cnt++;
        if (wr_cnt >= 6) rd5_after6++;
      end
    end
    if (bus_wr) begin
      regs[bus_addr] = bus_wdata;
      if (wr_cnt < 16) wr_cyc[wr_cnt] = cyc;
      wr_cnt++;
      if (expq.size() == 0)
        check(0, "R10 unexpected write", {bus_addr, bus_wdata}, 0);
      else begin
        logic [20:0] e;
        e = expq.pop_front();
        check({bus_addr, bus_wdata} == e, "R2-seq write", {bus_addr, bus_wdata}, e);
      end
    end
  end

  task automatic prep();
    for (int i = 0; i < 32; i++) regs[i] = 16'h0000;
    regs[3] = 16'h0030; regs[4] = 16'h0100; regs[8] = 16'hA3F5;
    regs[14] = 16'h0007; regs[20] = 16'h0015;
    wr_cnt = 0; rd5_cnt = 0; rd5_after6 = 0; expq.delete();
  endtask

  // expected writes in script order (field values per R2..R8)
  task automatic expect_writes(input logic [1:0] mode, input int upto);
    logic [15:0] r8;
    r8 = {regs[8][15:12], 4'b0100, regs[8][7:0]};        // R3
    push(5'd1, 16'h01FD);                                 // R2
    push(5'd8, r8);
    case (mode)                                           // R4
      2'd0: push(5'd3, regs[3] | 16'b0000_0000_0100_1111);
      2'd1: push(5'd3, 16'h018C);
      2'd2: push(5'd3, 16'h018F);
      default: push(5'd3, 16'h01CC);
    endcase
    if (upto > 3) begin
      push(5'd20, {regs[20][15:3], 1'b0, regs[20][1:0]}); // R6
      push(5'd20, {regs[20][15:3], 1'b1, regs[20][1:0]});
      push(5'd8, {r8[15:10], 2'b01, r8[7:0]});            // R7
    end
    if (upto > 6) push(5'd4, regs[4] | 16'h0008);         // R8
  endtask

  task automatic pulse_start(input logic [1:0] mode);
    @(negedge clk); start = 1'b1; align_mode = mode;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (done || err) break;
    end
  endtask

  task automatic full_run(input logic [1:0] mode);
    prep(); pll_ok = 1'b1; agc_ok = 1'b1;
    expect_writes(mode, 7);
    pulse_start(mode);
    check(busy, "R1 busy after start", busy, 1);
    wait_end();
    check(done && !err, "R9 done", {done, err}, 2);
    check(!busy, "R9 busy low at done", busy, 0);
    check(prev_rd == 5'd5 && last_rd == 5'd14, "R9 clearing reads", {prev_rd, last_rd}, {5'd5, 5'd14});
    check(expq.size() == 0 && wr_cnt == 7, "R3 all writes seen", wr_cnt, 7);
    check(wr_cyc[5] - wr_cyc[4] < UI_TMO, "R7 early exit on lock", wr_cyc[5] - wr_cyc[4], 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    misses++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    prep();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !err && !bus_wr && !bus_rd, "R1 reset state",
          {busy, done, err, bus_wr, bus_rd}, 0);

    // alignment modes; second start mid-run must be ignored (R11)
    prep(); pll_ok = 1'b1; agc_ok = 1'b1;
    expect_writes(2'd0, 7);
    pulse_start(2'd0);
    repeat (10) @(negedge clk);
    pulse_start(2'd3);
    wait_end();
    check(done && expq.size() == 0 && wr_cnt == 7, "R11 start ignored while busy", wr_cnt, 7);
    full_run(2'd1);
    full_run(2'd2);
    full_run(2'd3);
    full_run(2'd0);

    // PLL never locks: R5
    prep(); pll_ok = 1'b0; agc_ok = 1'b1;
    expect_writes(2'd0, 3);
    pulse_start(2'd0);
    check(!done, "R11 done cleared by start", done, 0);
    wait_end();
    check(err && !done, "R5 error flag", {err, done}, 2);
    check(rd5_cnt == POLL_MAX, "R5 poll count", rd5_cnt, POLL_MAX);
    repeat (20) @(negedge clk);
    check(!busy && wr_cnt == 3 && expq.size() == 0, "R5 quiet after error", wr_cnt, 3);

    // gain lock only after timeout: R7 timeout path then R8
    prep(); pll_ok = 1'b1; agc_ok = 1'b0;
    expect_writes(2'd2, 7);
    pulse_start(2'd2);
    check(!err, "R11 err cleared by start", err, 0);
    for (int i = 0; i < 3000 && wr_cnt < 6; i++) @(negedge clk);
    agc_ok = 1'b1;
    wait_end();
    check(done && wr_cnt == 7, "R8 completes after timeout", wr_cnt, 7);
    check(wr_cyc[5] - wr_cyc[4] >= UI_TMO && wr_cyc[5] - wr_cyc[4] <= UI_TMO + 20,
          "R7 timeout window", wr_cyc[5] - wr_cyc[4], UI_TMO);

    // gain never locks: R8 error after timeout and POLL_MAX polls
    prep(); pll_ok = 1'b1; agc_ok = 1'b0;
    expect_writes(2'd0, 6);
    pulse_start(2'd0);
    wait_end();
    check(err && !done, "R8 error flag", {err, done}, 2);
    check(rd5_after6 == POLL_MAX, "R8 poll count", rd5_after6, POLL_MAX);
    check(wr_cnt == 6 && expq.size() == 0, "R8 no reset write", wr_cnt, 6);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule